// File: doc/BRIEF.md
# Fractional PLL Output Rate Calculator

This unit works out the frequency a PLL is producing from the reference frequency and the packed fields of the PLL's divider control words. After a start pulse it takes a snapshot of the inputs and forms a 64-bit numerator and a divisor. It then runs a shift-subtract divider and returns the truncated integer rate, together with a one-cycle done pulse.

There are two modes. The integer mode uses only the feedback multiplier, the pre-divider and a power-of-two post-divider. The fractional mode adds a signed sixteen-bit fraction, weighted 1/65536, to the feedback multiplier. A zero pre-divider cannot be divided by. In that case the unit returns zero and raises an error flag, and it does not start the divider.

Top module: `pll_rate_calc`

## Requirements
- R1: Field positions. In `div_word0`, the multiplier M sits in bits 21:12, the pre-divider P in bits 9:4 and the post-divider exponent S in bits 2:0. In `div_word1`, the fraction K is bits 15:0, read as a two's-complement signed value. No other bit of either word affects the result.
- R2: With `frac_mode`=0, `rate` = floor(fin*M / (P<<S)). `div_word1` has no effect on the result.
- R3: With `frac_mode`=1, `rate` = floor(fin*(M*65536+K) / ((P*65536)<<S)).
- R4: The numerator is carried in 64 bits, so fin=2^32-1 with M=1023 gives the exact product without wraparound.
- R5: The result is the truncated quotient. Any remainder is dropped.
- R6: If P=0, the unit returns `rate`=0 with `err_pdiv`=1. `done` is high in the cycle after the accepting edge, and `busy` never rises.
- R7: In fractional mode, a negative multiplier term (M*65536+K < 0) returns `rate`=0 with `err_pdiv`=0. `done` is high in the cycle after the accepting edge.
- R8: A start accepted at clock edge n raises `busy` after edge n. After edge n+64, `busy` is low and `done` is high for exactly one cycle.
- R9: A start that arrives while `busy` is high is ignored. The running result, its latency and the number of done pulses are all unchanged.
- R10: After reset, `busy`, `done` and `err_pdiv` are 0 and `rate` is 0.
- R11: `rate` changes only in a cycle where `done` is high. It holds its value between calculations, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; sampled when not busy |
| frac_mode | input | 1 | 0 = integer mode, 1 = fractional mode |
| fin | input | FIN_W (32) | Reference input frequency |
| div_word0 | input | 32 | Divider control word with the M, P and S fields |
| div_word1 | input | 32 | Divider control word with the K field |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_pdiv | output | 1 | Last calculation had P=0 |
| rate | output | Q_W (64) | Computed output frequency |

## Verification
The divider leaves a quotient bit behind on every one of its 64 steps. A wrong remainder or a misaligned shift therefore shows up as a `rate` that differs from the bench's own 64-bit arithmetic, and it shows as soon as `done` pulses. A step counter that is off by one moves the `done` pulse away from the 65th cycle. Decode faults in field position, sign extension of K or the mode choice appear as wrong rates for vectors that set neighbouring bits, negative fractions or junk in the unused word. Every such fault is visible at the next completion, at most 65 cycles after start.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

  // Field placement in the divider control words (decoded by neighbours)
  localparam int CW      = 32;
  localparam int M_LSB   = 12;
  localparam int M_W     = 10;
  localparam int P_LSB   = 4;
  localparam int P_W     = 6;
  localparam int S_LSB   = 0;
  localparam int S_W     = 3;
  localparam int K_W     = 16;
  localparam int FRAC_SH = 16;

  // Signed multiplier term width and divisor width
  localparam int TERM_W  = M_W + FRAC_SH + 1;
  localparam int DEN_W   = P_W + FRAC_SH + (1 << S_W) - 1;

  function automatic logic [M_W-1:0] get_mult(input logic [CW-1:0] w);
    return w[M_LSB +: M_W];
  endfunction

  function automatic logic [P_W-1:0] get_prediv(input logic [CW-1:0] w);
    return w[P_LSB +: P_W];
  endfunction

  function automatic logic [S_W-1:0] get_postexp(input logic [CW-1:0] w);
    return w[S_LSB +: S_W];
  endfunction

  function automatic logic [K_W-1:0] get_frac(input logic [CW-1:0] w);
    return w[K_W-1:0];
  endfunction

  // Feedback term: M (integer) or M*2^16 + signed K (fractional)
  function automatic logic signed [TERM_W-1:0] mult_term(
      input logic [M_W-1:0] m, input logic [K_W-1:0] k, input logic frac);
    logic signed [TERM_W-1:0] mt;
    logic signed [TERM_W-1:0] kt;
    mt = $signed(TERM_W'(m));
    kt = $signed({{(TERM_W-K_W){k[K_W-1]}}, k});
    if (frac) return (mt <<< FRAC_SH) + kt;
    return mt;
  endfunction

  // Divisor: P (or P*2^16) shifted left by S
  function automatic logic [DEN_W-1:0] divisor_of(
      input logic [P_W-1:0] p, input logic [S_W-1:0] s, input logic frac);
    logic [DEN_W-1:0] b;
    b = DEN_W'(p);
    if (frac) b = b << FRAC_SH;
    return b << s;
  endfunction

endpackage

// File: rtl/pll_field_decode.sv
module pll_field_decode
  import pll_calc_pkg::*;
#(
  parameter int FIN_W = 32,
  parameter int Q_W   = 64
) (
  input  logic [FIN_W-1:0] fin,
  input  logic [CW-1:0]    word0,
  input  logic [CW-1:0]    word1,
  input  logic             frac,
  output logic [Q_W-1:0]   numer,
  output logic [DEN_W-1:0] denom,
  output logic             pdiv_zero,
  output logic             term_neg
);
  logic [M_W-1:0]           m_f;
  logic [P_W-1:0]           p_f;
  logic [S_W-1:0]           s_f;
  logic [K_W-1:0]           k_f;
  logic signed [TERM_W-1:0] term;
  logic [TERM_W-2:0]        mag;
  logic                     unused_bits;

  always_comb begin
    m_f   = get_mult(word0);
    p_f   = get_prediv(word0);
    s_f   = get_postexp(word0);
    k_f   = get_frac(word1);
    term  = mult_term(m_f, k_f, frac);
    mag   = term[TERM_W-2:0];
    term_neg  = term[TERM_W-1];
    pdiv_zero = (p_f == '0);
    numer = term_neg ? '0 : Q_W'(fin) * Q_W'(mag);
    denom = divisor_of(p_f, s_f, frac);
  end

  assign unused_bits = ^{word0[CW-1:M_LSB+M_W], word0[M_LSB-1:P_LSB+P_W],
                         word0[P_LSB-1:S_LSB+S_W], word1[CW-1:K_W]};

endmodule

// File: rtl/pll_seq_divider.sv
module pll_seq_divider #(
  parameter int Q_W   = 64,
  parameter int DEN_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [Q_W-1:0]   dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic             busy,
  output logic             last_step,
  output logic [Q_W-1:0]   q_next
);
  localparam int CNT_W = $clog2(Q_W);

  logic [Q_W-1:0]   dq;
  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] dv;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W:0]   trial;
  logic             qbit;
  logic [DEN_W-1:0] rem_nxt;

  always_comb begin
    trial   = {rem, dq[Q_W-1]};
    qbit    = (trial >= {1'b0, dv});
    rem_nxt = qbit ? DEN_W'(trial - {1'b0, dv}) : trial[DEN_W-1:0];
    q_next  = {dq[Q_W-2:0], qbit};
    last_step = busy && (cnt == CNT_W'(Q_W-1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq   <= '0;
      rem  <= '0;
      dv   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      dq   <= dividend;
      rem  <= '0;
      dv   <= divisor;
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      dq   <= q_next;
      rem  <= rem_nxt;
      cnt  <= cnt + 1'b1;
      if (last_step) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pll_calc_pkg::*;
#(
  parameter int FIN_W = 32,
  parameter int Q_W   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             frac_mode,
  input  logic [FIN_W-1:0] fin,
  input  logic [31:0]      div_word0,
  input  logic [31:0]      div_word1,
  output logic             busy,
  output logic             done,
  output logic             err_pdiv,
  output logic [Q_W-1:0]   rate
);
  logic [Q_W-1:0]   numer;
  logic [DEN_W-1:0] denom;
  logic             pdiv_zero;
  logic             term_neg;
  logic             accept;
  logic             short_path;
  logic             load;
  logic             last_step;
  logic [Q_W-1:0]   q_next;

  pll_field_decode #(.FIN_W(FIN_W), .Q_W(Q_W)) u_dec (
    .fin(fin), .word0(div_word0), .word1(div_word1), .frac(frac_mode),
    .numer(numer), .denom(denom), .pdiv_zero(pdiv_zero), .term_neg(term_neg)
  );

  assign accept     = start && !busy;
  assign short_path = accept && (pdiv_zero || term_neg);
  assign load       = accept && !(pdiv_zero || term_neg);

  pll_seq_divider #(.Q_W(Q_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(load), .dividend(numer), .divisor(denom),
    .busy(busy), .last_step(last_step), .q_next(q_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      err_pdiv <= 1'b0;
      rate     <= '0;
    end else begin
      done <= 1'b0;
      if (short_path) begin
        done     <= 1'b1;
        rate     <= '0;
        err_pdiv <= pdiv_zero;
      end else if (load) begin
        err_pdiv <= 1'b0;
      end else if (last_step) begin
        done <= 1'b1;
        rate <= q_next;
      end
    end
  end

endmodule

// File: rtl/pll_rate_calc_chk.sv
module pll_rate_calc_chk #(
  parameter int Q_W = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           err_pdiv,
  input logic [Q_W-1:0] rate,
  input logic           accept,
  input logic           short_path,
  input logic           last_step
);
  logic [$clog2(Q_W)+1:0] busy_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cycles <= '0;
    else if (busy) busy_cycles <= busy_cycles + 1'b1;
    else busy_cycles <= '0;
  end

  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !short_path |=> busy); // R8
  AST_SHORT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    short_path |=> done && !busy); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done && (busy_cycles == ($clog2(Q_W)+2)'(Q_W))); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_step |=> busy); // R9
  AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate) |-> done); // R11
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && err_pdiv |-> rate == '0); // R6

endmodule

bind pll_rate_calc pll_rate_calc_chk #(.Q_W(Q_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err_pdiv(err_pdiv),
  .rate(rate), .accept(accept), .short_path(short_path), .last_step(last_step)
);

// File: tb/sim_pll_rate_calc.sv
`timescale 1ns/1ps
module sim_pll_rate_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        frac_mode = 1'b0;
  logic [31:0] fin = '0;
  logic [31:0] div_word0 = '0;
  logic [31:0] div_word1 = '0;
  logic        busy, done, err_pdiv;
  logic [63:0] rate;
  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pll_rate_calc u0 (.*);

  function automatic logic [31:0] pack0(int m, int p, int s);
    return (32'(m) << 12) | (32'(p) << 4) | 32'(s);
  endfunction

  function automatic longint unsigned model(longint f, logic [31:0] w0,
      logic [31:0] w1, bit fm, output bit e);
    longint m, p, s, k, t, den;
    longint unsigned num;
    m = (w0 >> 12) & 1023; p = (w0 >> 4) & 63; s = w0 & 7;
    k = longint'($signed(w1[15:0]));
    e = (p == 0);
    if (p == 0) return 0;
    if (fm) begin t = m * 65536 + k; den = (p * 65536) << s; end
    else    begin t = m;             den = p << s; end
    if (t < 0) return 0;
    num = longint'(f) * t;
    return num / longint'(den);
  endfunction

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Run one calculation, check rate, error flag and latency
  task automatic run_case(string tag, logic [31:0] f, logic [31:0] w0,
      logic [31:0] w1, bit fm);
    bit e; longint unsigned exp; int lat; int exp_lat;
    exp = model(f, w0, w1, fm, e);
    exp_lat = (e || (exp == 0 && fm && model_neg(w0, w1))) ? 1 : 65;
    @(negedge clk);
    fin = f; div_word0 = w0; div_word1 = w1; frac_mode = fm; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    check({tag, " rate"}, rate, exp);
    check({tag, " err"}, err_pdiv, e);
    check({tag, " latency"}, lat, exp_lat);
  endtask

  function automatic bit model_neg(logic [31:0] w0, logic [31:0] w1);
    longint m, k;
    m = (w0 >> 12) & 1023;
    k = longint'($signed(w1[15:0]));
    return (m * 65536 + k) < 0;
  endfunction

  task automatic t_reset();
    check("R10 busy", busy, 0);
    check("R10 done", done, 0);
    check("R10 err", err_pdiv, 0);
    check("R10 rate", rate, 0);
  endtask

  task automatic t_integer();
    run_case("R2 int 225/3/0", 24000000, pack0(225, 3, 0), 0, 0);
    run_case("R2 int 375/3/1", 24000000, pack0(375, 3, 1), 0, 0);
    run_case("R2 int word1 ignored", 24000000, pack0(225, 3, 0), 32'h0000_7fff, 0);
  endtask

  task automatic t_fraction();
    run_case("R3 frac pos K", 24000000, pack0(173, 2, 1), 16384, 1);
    run_case("R3 frac neg K", 24000000, pack0(262, 2, 3), 32'h0000_fffb, 1);
    run_case("R3 frac max divisor", 32'hffff_ffff, pack0(1023, 63, 7), 32'h0000_7fff, 1);
  endtask

  task automatic t_fields();
    run_case("R1 junk bits", 24000000, pack0(350, 3, 2) | 32'hffc0_0c08,
             32'hffff_0000 | 32'd17511, 1);
  endtask

  task automatic t_trunc_wide();
    run_case("R5 truncation", 1000, pack0(1, 3, 0), 0, 0);
    run_case("R4 wide product", 32'hffff_ffff, pack0(1023, 1, 0), 0, 0);
  endtask

  task automatic t_errors();
    run_case("R6 pdiv zero", 24000000, pack0(100, 0, 1), 0, 0);
    check("R6 busy stays low", busy, 0);
    run_case("R7 negative term", 24000000, pack0(0, 3, 0), 32'h0000_ffff, 1);
  endtask

  task automatic t_ignore();
    int lat; int extra;
    bit e; longint unsigned exp;
    exp = model(24000000, pack0(300, 3, 1), 0, 0, e);
    @(negedge clk);
    fin = 24000000; div_word0 = pack0(300, 3, 1); div_word1 = 0;
    frac_mode = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    check("R8 busy after start", busy, 1);
    while (!done && lat < 200) begin
      @(negedge clk); lat++;
      if (lat == 10) begin
        fin = 5; div_word0 = pack0(7, 1, 0); start = 1'b1;
      end else start = 1'b0;
    end
    check("R9 rate kept", rate, exp);
    check("R9 latency kept", lat, 65);
    @(negedge clk);
    check("R8 done one cycle", done, 0);
    check("R8 busy low after done", busy, 0);
    extra = 0;
    for (int i = 0; i < 70; i++) begin @(negedge clk); if (done) extra++; end
    check("R9 no extra done", extra, 0);
    check("R11 rate held", rate, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_integer();
    t_fraction();
    t_fields();
    t_trunc_wide();
    t_errors();
    t_ignore();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule